// File: doc/BRIEF.md
# Dual Maskable Time-of-Day Alarm

This block watches a running clock and raises a flag when the time reaches one of two programmed alarm points. Each alarm has four byte registers, one for each of seconds, minutes, hours and day-of-week. The top bit of each byte is a "don't care" mask, and the low seven bits hold the value to compare. The time-keeping logic supplies the current time bytes and a one-cycle tick once per second. On each tick, every unmasked field is compared with the live time. When all of them agree, the flag for that alarm is set and stays set until the host accesses that alarm's registers.

The masks set how often an alarm repeats. With no mask set, the alarm repeats weekly. It repeats daily when the day field is masked, hourly when day and hour are masked, once a minute when minutes are masked as well, and every second when all four fields are masked. A routing control selects one of two interrupt schemes: each alarm has its own active-low interrupt line, or both alarms share the first line. Each alarm has its own enable bit that gates its interrupt.

Top module: `tod_alarm_pair`

## Requirements
- R1: After reset, both flags are 0, both interrupt lines are high, and all eight alarm registers read 0x00.
- R2: The alarm registers are read at `acc_addr` and written at `acc_addr` when `wr_en` is high, with all 8 bits stored.
  - Alarm 0 uses addresses 0x07–0x0A and alarm 1 uses 0x0B–0x0E.
  - Within each alarm, the field order is seconds, minutes, hours, day.
  - `rdata` shows the addressed register in the same cycle.
  - Any other address reads 0x00, and a write to it changes nothing.
- R3: With all masks clear (bit 7 = 0), a tick sets the alarm's flag on the following clock edge only if bits 6:0 of seconds, minutes, hours and day all equal the current time bytes.
- R4: With only the day byte's bit 7 set, the day field is ignored, so the alarm fires daily.
- R5: With the day and hours masks set, only minutes and seconds are compared, so the alarm fires hourly.
- R6: With the day, hours and minutes masks set, only seconds are compared, so the alarm fires once a minute.
- R7: With all four masks set, every tick sets the flag.
- R8: The hours field is compared over all of bits 6:0. As a result, the 12/24-hour mode bit and the PM bit must also match.
- R9: When `tick` is low, no flag is set, even if the alarm fields match the time.
- R10: A flag stays set until a read strobe or a write strobe addresses one of that alarm's four registers. The flag then clears on the next edge.
  - An access to the other alarm leaves the flag unchanged.
  - If a tick match falls in the same cycle as the access, the flag is set.
- R11: With `irq_split` = 1, `irq0_n` is low exactly when flag 0 and enable bit 0 are both 1, and `irq1_n` does the same for alarm 1.
- R12: With `irq_split` = 0, `irq0_n` is low when either alarm has both its flag and its enable bit set, and `irq1_n` stays high.
- R13: The interrupt lines follow changes of `alm_ien` and `irq_split` in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse once per second |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte (12/24 encoded) |
| cur_day | input | 8 | Current day-of-week byte |
| acc_addr | input | 7 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (clears the accessed alarm's flag) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `acc_addr` |
| alm_ien | input | 2 | Interrupt enable per alarm |
| irq_split | input | 1 | 1: separate interrupt lines, 0: shared line on `irq0_n` |
| flag | output | 2 | Alarm flags |
| irq0_n | output | 1 | Active-low interrupt line 0 |
| irq1_n | output | 1 | Active-low interrupt line 1 |

## Verification
The assertions check several rules on every cycle:
- A flag rises only after a tick with a match.
- A flag falls only after an access to its own alarm.
- A stored byte is unchanged unless it is written.
- An interrupt line is never low without a flag.
- The second line stays idle in shared mode.

Some behaviour only the bench's scenarios can show, because it needs the programmed register values and the time inputs together. This covers the repeat period produced by each mask combination, the exact hour comparison including the mode and PM bits, and the same-cycle priority of set over clear.

// File: rtl/alm_pkg.sv
// Package: shared sizes and field ordering for the dual alarm block.
// Assumes the number of fields per alarm is a power of two.
package alm_pkg;
    localparam int ALARMS = 2;
    localparam int FIELDS = 4;

    typedef enum logic [1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_DAY  = 2'd3
    } field_e;
endpackage

// File: rtl/alm_bank.sv
// Module: storage for one alarm's field bytes.
// Each byte loads from wdata when its one-hot select is high.
// Assumes at most one select bit is high in any cycle.
module alm_bank #(
    parameter int DATA_W = 8,
    parameter int FIELDS = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [FIELDS-1:0]               wr_sel_i,
    input  logic [DATA_W-1:0]               wdata_i,
    output logic [FIELDS-1:0][DATA_W-1:0]   q_o
);
    for (genvar f = 0; f < FIELDS; f++) begin : g_fld
        // Load one field byte on its select, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)           q_o[f] <= '0;
            else if (wr_sel_i[f]) q_o[f] <= wdata_i;
        end

        assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_sel_i[f] |=> $stable(q_o[f]));
    end
endmodule

// File: rtl/alm_match.sv
// Module: compare one alarm's fields against the live time.
// A field agrees when its top bit (mask) is set, or when its remaining
// bits equal the same bits of the current time byte.
module alm_match #(
    parameter int DATA_W = 8,
    parameter int FIELDS = 4
) (
    input  logic [FIELDS-1:0][DATA_W-1:0]   alarm_i,
    input  logic [FIELDS-1:0][DATA_W-1:0]   now_i,
    output logic                            hit_o
);
    logic [FIELDS-1:0] agree;

    for (genvar f = 0; f < FIELDS; f++) begin : g_cmp
        // Per-field compare of the value bits, overridden by the mask bit.
        assign agree[f] = alarm_i[f][DATA_W-1] |
                          (alarm_i[f][DATA_W-2:0] == now_i[f][DATA_W-2:0]);
    end

    assign hit_o = &agree;
endmodule

// File: rtl/alm_flag.sv
// Module: sticky alarm flag.
// The flag is set by a tick with a match and cleared by a host access.
// When both happen in the same cycle, the set wins.
module alm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hit_i,
    input  logic clr_i,
    output logic flag_o
);
    // Set on a tick match, otherwise clear on an access, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag_o <= 1'b0;
        else if (tick_i && hit_i)   flag_o <= 1'b1;
        else if (clr_i)             flag_o <= 1'b0;
    end

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && hit_i) |=> flag_o);
    assert_flag_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(tick_i && hit_i));
    assert_flag_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(clr_i));
endmodule

// File: rtl/alm_irq_route.sv
// Module: gate the flags with their enables and route them to two
// active-low lines, either separately or combined on line 0.
// Purely combinational.
module alm_irq_route (
    input  logic [1:0] flag_i,
    input  logic [1:0] ien_i,
    input  logic       split_i,
    output logic       irq0_n_o,
    output logic       irq1_n_o
);
    logic [1:0] active;

    // Route the enabled flags to the output lines.
    always_comb begin
        active = flag_i & ien_i;
        if (split_i) begin
            irq0_n_o = ~active[0];
            irq1_n_o = ~active[1];
        end else begin
            irq0_n_o = ~(|active);
            irq1_n_o = 1'b1;
        end
    end
endmodule

// File: rtl/tod_alarm_pair.sv
// Module: top level of the dual maskable time-of-day alarm.
// It decodes the register window and holds two alarm banks with their
// comparators and flags, then drives the interrupt routing.
// Assumes tick is a single-cycle pulse and the time bytes are stable
// while it is high.
module tod_alarm_pair #(
    parameter int          DATA_W    = 8,
    parameter int          ADDR_W    = 7,
    parameter logic [6:0]  BASE_ADDR = 7'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DATA_W-1:0] cur_sec,
    input  logic [DATA_W-1:0] cur_min,
    input  logic [DATA_W-1:0] cur_hour,
    input  logic [DATA_W-1:0] cur_day,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [1:0]        alm_ien,
    input  logic              irq_split,
    output logic [1:0]        flag,
    output logic              irq0_n,
    output logic              irq1_n
);
    import alm_pkg::*;

    localparam int SPAN   = ALARMS * FIELDS;
    localparam int FSEL_W = $clog2(FIELDS);

    logic [ADDR_W-1:0]                           offset;
    logic                                        in_range;
    logic [FSEL_W-1:0]                           fidx;
    logic [FIELDS-1:0][DATA_W-1:0]               now_pk;
    logic [ALARMS-1:0][FIELDS-1:0][DATA_W-1:0]   bank;
    logic [ALARMS-1:0]                           a_hit;
    logic [ALARMS-1:0]                           match;
    logic [ALARMS-1:0]                           clr;

    // Pack the time bytes in field order: seconds, minutes, hours, day.
    assign now_pk[FLD_SEC]  = cur_sec;
    assign now_pk[FLD_MIN]  = cur_min;
    assign now_pk[FLD_HOUR] = cur_hour;
    assign now_pk[FLD_DAY]  = cur_day;

    // Window decode: offset into the alarm block and the field index.
    assign offset   = acc_addr - ADDR_W'(BASE_ADDR);
    assign in_range = (int'(acc_addr) >= int'(BASE_ADDR)) &&
                      (int'(acc_addr) <  int'(BASE_ADDR) + SPAN);
    assign fidx     = offset[FSEL_W-1:0];

    for (genvar a = 0; a < ALARMS; a++) begin : g_alm
        logic [FIELDS-1:0] wr_sel;

        assign a_hit[a] = in_range && ((int'(offset) / FIELDS) == a);
        assign wr_sel   = (wr_en && a_hit[a]) ? (FIELDS'(1) << fidx) : '0;
        assign clr[a]   = (wr_en || rd_en) && a_hit[a];

        alm_bank #(.DATA_W(DATA_W), .FIELDS(FIELDS)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel_i (wr_sel),
            .wdata_i  (wdata),
            .q_o      (bank[a])
        );

        alm_match #(.DATA_W(DATA_W), .FIELDS(FIELDS)) u_match (
            .alarm_i (bank[a]),
            .now_i   (now_pk),
            .hit_o   (match[a])
        );

        alm_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick),
            .hit_i  (match[a]),
            .clr_i  (clr[a]),
            .flag_o (flag[a])
        );
    end

    // Read mux: the addressed alarm byte, or zero outside the window.
    always_comb begin
        rdata = '0;
        for (int a = 0; a < ALARMS; a++)
            for (int f = 0; f < FIELDS; f++)
                if (in_range && int'(offset) == a * FIELDS + f)
                    rdata = bank[a][f];
    end

    alm_irq_route u_route (
        .flag_i   (flag),
        .ien_i    (alm_ien),
        .split_i  (irq_split),
        .irq0_n_o (irq0_n),
        .irq1_n_o (irq1_n)
    );

    assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq0_n |-> (flag != 2'b00));
    assert_shared_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_split |-> irq1_n);
    assert_one_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr & {ALARMS{wr_en}}));
endmodule

// File: tb/sim_tod_alarm_pair.sv
module sim_tod_alarm_pair;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] tcur [4];
    logic [6:0] acc_addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] alm_ien = 2'b00;
    logic       irq_split = 1'b1;
    logic [1:0] flag;
    logic       irq0_n, irq1_n;

    int checks = 0;
    int failures = 0;
    logic [7:0] m_reg [2][4];
    logic [1:0] m_flag;

    always #(PERIOD/2) clk = ~clk;

    tod_alarm_pair u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cur_sec(tcur[0]), .cur_min(tcur[1]), .cur_hour(tcur[2]), .cur_day(tcur[3]),
        .acc_addr(acc_addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .rdata(rdata), .alm_ien(alm_ien), .irq_split(irq_split),
        .flag(flag), .irq0_n(irq0_n), .irq1_n(irq1_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit mdl_match(input int a);
        for (int f = 0; f < 4; f++)
            if (!m_reg[a][f][7] && (m_reg[a][f][6:0] != tcur[f][6:0])) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [1:0] mdl_irq();
        logic [1:0] act;
        act = m_flag & alm_ien;
        if (irq_split) return ~act;
        return {1'b1, ~(|act)};
    endfunction

    function automatic int alarm_of(input logic [6:0] ad);
        if (ad >= 7 && ad <= 10) return 0;
        if (ad >= 11 && ad <= 14) return 1;
        return -1;
    endfunction

    task automatic cmp_out(input string tag);
        logic [1:0] ei;
        ei = mdl_irq();
        chk(tag, {28'd0, flag, irq1_n, irq0_n}, {28'd0, m_flag, ei});
    endtask

    // One clock: drive at the falling edge, update the model, check after the rising edge.
    task automatic step(input string tag, input bit tk, input bit rd, input bit wr,
                        input logic [6:0] ad, input logic [7:0] wd);
        logic [1:0] nf;
        int al;
        tick = tk; rd_en = rd; wr_en = wr; acc_addr = ad; wdata = wd;
        al = alarm_of(ad);
        for (int a = 0; a < 2; a++) begin
            nf[a] = m_flag[a];
            if ((rd || wr) && al == a) nf[a] = 1'b0;
            if (tk && mdl_match(a)) nf[a] = 1'b1;
        end
        if (wr && al >= 0) m_reg[al][(ad - 7) % 4] = wd;
        @(posedge clk);
        #1;
        m_flag = nf;
        tick = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        cmp_out(tag);
        @(negedge clk);
    endtask

    task automatic wr_alarm(input int a, input logic [7:0] s, input logic [7:0] m,
                            input logic [7:0] h, input logic [7:0] d);
        step("R2", 0, 0, 1, 7'(7 + 4*a), s);
        step("R2", 0, 0, 1, 7'(8 + 4*a), m);
        step("R2", 0, 0, 1, 7'(9 + 4*a), h);
        step("R2", 0, 0, 1, 7'(10 + 4*a), d);
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m,
                            input logic [7:0] h, input logic [7:0] d);
        tcur[0] = s; tcur[1] = m; tcur[2] = h; tcur[3] = d;
    endtask

    task automatic peek(input string tag, input logic [6:0] ad, input logic [7:0] exp);
        acc_addr = ad;
        #1;
        chk(tag, {24'd0, rdata}, {24'd0, exp});
    endtask

    initial begin
        #(PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h0A1C));
        set_time(8'h00, 8'h00, 8'h00, 8'h01);
        for (int a = 0; a < 2; a++) for (int f = 0; f < 4; f++) m_reg[a][f] = 8'h00;
        m_flag = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", {30'd0, flag}, 32'd0);
        chk("R1", {30'd0, irq1_n, irq0_n}, 32'd3);
        for (int ad = 7; ad <= 14; ad++) peek("R1", 7'(ad), 8'h00);
        @(negedge clk);

        // R2: map, readback, unmapped addresses
        wr_alarm(0, 8'h56, 8'h34, 8'h12, 8'h03);
        wr_alarm(1, 8'hA1, 8'hB2, 8'hC3, 8'hD4);
        peek("R2", 7'h07, 8'h56); peek("R2", 7'h09, 8'h12); peek("R2", 7'h0A, 8'h03);
        peek("R2", 7'h0B, 8'hA1); peek("R2", 7'h0E, 8'hD4);
        step("R2", 0, 0, 1, 7'h0F, 8'hFF);
        step("R2", 0, 0, 1, 7'h06, 8'hEE);
        peek("R2", 7'h0F, 8'h00); peek("R2", 7'h06, 8'h00);
        peek("R2", 7'h08, 8'h34); peek("R2", 7'h0D, 8'hC3);

        // R3/R9: weekly compare on alarm 0
        wr_alarm(1, 8'h80, 8'h80, 8'h80, 8'h80);
        step("R10", 0, 1, 0, 7'h0B, 8'h00);
        alm_ien = 2'b11; irq_split = 1'b1;
        set_time(8'h56, 8'h34, 8'h12, 8'h04);
        step("R3", 1, 0, 0, 7'h00, 8'h00);
        chk("R3", {31'd0, flag[0]}, 32'd0);
        set_time(8'h56, 8'h34, 8'h12, 8'h03);
        step("R9", 0, 0, 0, 7'h00, 8'h00);
        chk("R9", {31'd0, flag[0]}, 32'd0);
        step("R3", 1, 0, 0, 7'h00, 8'h00);
        chk("R3", {31'd0, flag[0]}, 32'd1);
        chk("R11", {31'd0, irq0_n}, 32'd0);

        // R10: access to the other alarm keeps the flag, own access clears it
        step("R10", 0, 1, 0, 7'h0C, 8'h00);
        chk("R10", {31'd0, flag[0]}, 32'd1);
        step("R10", 0, 1, 0, 7'h09, 8'h00);
        chk("R10", {31'd0, flag[0]}, 32'd0);
        step("R10", 1, 1, 0, 7'h07, 8'h00);
        chk("R10", {31'd0, flag[0]}, 32'd1);
        step("R10", 0, 0, 1, 7'h0A, 8'h03);
        chk("R10", {31'd0, flag[0]}, 32'd0);

        // R4..R7: mask combinations on alarm 1 (minutes 30, seconds 15, hour 08, day 2)
        set_time(8'h15, 8'h30, 8'h08, 8'h05);
        wr_alarm(1, 8'h15, 8'h30, 8'h08, 8'h82);
        step("R4", 1, 0, 0, 7'h00, 8'h00);
        chk("R4", {31'd0, flag[1]}, 32'd1);
        step("R4", 0, 1, 0, 7'h0B, 8'h00);
        set_time(8'h15, 8'h30, 8'h09, 8'h05);
        step("R4", 1, 0, 0, 7'h00, 8'h00);
        chk("R4", {31'd0, flag[1]}, 32'd0);
        wr_alarm(1, 8'h15, 8'h30, 8'h88, 8'h82);
        step("R5", 1, 0, 0, 7'h00, 8'h00);
        chk("R5", {31'd0, flag[1]}, 32'd1);
        step("R5", 0, 1, 0, 7'h0B, 8'h00);
        set_time(8'h15, 8'h31, 8'h09, 8'h05);
        step("R5", 1, 0, 0, 7'h00, 8'h00);
        chk("R5", {31'd0, flag[1]}, 32'd0);
        wr_alarm(1, 8'h15, 8'hB0, 8'h88, 8'h82);
        step("R6", 1, 0, 0, 7'h00, 8'h00);
        chk("R6", {31'd0, flag[1]}, 32'd1);
        step("R6", 0, 1, 0, 7'h0B, 8'h00);
        set_time(8'h16, 8'h31, 8'h09, 8'h05);
        step("R6", 1, 0, 0, 7'h00, 8'h00);
        chk("R6", {31'd0, flag[1]}, 32'd0);
        wr_alarm(1, 8'h95, 8'hB0, 8'h88, 8'h82);
        step("R7", 1, 0, 0, 7'h00, 8'h00);
        chk("R7", {31'd0, flag[1]}, 32'd1);

        // R8: hour mode and PM bits take part in the compare
        wr_alarm(0, 8'h80, 8'h80, 8'h72, 8'h80);
        set_time(8'h00, 8'h00, 8'h52, 8'h01);
        step("R8", 1, 0, 0, 7'h00, 8'h00);
        chk("R8", {31'd0, flag[0]}, 32'd0);
        set_time(8'h00, 8'h00, 8'h12, 8'h01);
        step("R8", 1, 0, 0, 7'h00, 8'h00);
        chk("R8", {31'd0, flag[0]}, 32'd0);
        set_time(8'h00, 8'h00, 8'h72, 8'h01);
        step("R8", 1, 0, 0, 7'h00, 8'h00);
        chk("R8", {31'd0, flag[0]}, 32'd1);

        // R11/R12/R13: routing follows enables and mode without a clock edge
        step("R10", 0, 1, 0, 7'h0B, 8'h00);
        alm_ien = 2'b01; irq_split = 1'b1; #1;
        chk("R13", {30'd0, irq1_n, irq0_n}, 32'd2);
        alm_ien = 2'b10; #1;
        chk("R11", {30'd0, irq1_n, irq0_n}, 32'd3);
        irq_split = 1'b0; alm_ien = 2'b01; #1;
        chk("R12", {30'd0, irq1_n, irq0_n}, 32'd2);
        step("R7", 1, 0, 0, 7'h00, 8'h00);
        alm_ien = 2'b10; #1;
        chk("R12", {30'd0, irq1_n, irq0_n}, 32'd2);
        irq_split = 1'b1; #1;
        chk("R11", {30'd0, irq1_n, irq0_n}, 32'd1);
        @(negedge clk);

        // Random phase against the bench model
        for (int i = 0; i < 600; i++) begin
            int r;
            logic [6:0] ad;
            logic [7:0] wd;
            for (int f = 0; f < 4; f++) tcur[f] = 8'($urandom_range(0, 2));
            alm_ien = 2'($urandom);
            irq_split = 1'($urandom);
            r = $urandom_range(0, 9);
            ad = 7'($urandom_range(5, 16));
            wd = {1'($urandom_range(0, 3) == 0), 7'($urandom_range(0, 2))};
            if (r < 2)      step("R3", 1'($urandom), 0, 1, ad, wd);
            else if (r < 4) step("R10", 1'($urandom), 1, 0, ad, 8'h00);
            else            step("R3", 1'($urandom), 0, 0, ad, 8'h00);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule